// File: doc/BRIEF.md
# Four-Stage Keyed Watchdog Timer

This block is a watchdog timer that escalates through four stages in a fixed order. A prescaler turns the input clock into watchdog ticks. Each stage counts ticks up to its own timeout and then takes its own action: nothing, an interrupt, a CPU reset pulse or a system reset pulse. The sequence then moves on to the next stage, and after the last stage it returns to the first. Software keeps the sequence in its first stage by writing the feed register often enough.

Configuration sits behind a key. A write of the key value to the key register opens the other configuration registers. Any other value written there closes them again. While they are closed, writes to the configuration, prescale, timeout and feed registers have no effect. Interrupts can be signalled as a sticky level, as a one-clock pulse, or both. The two reset outputs are pulses whose lengths are programmed separately. The watchdog runs when the enable bit or the boot-mode bit is set.

The register write port is a plain single-cycle strobe with address and data. Bus protocol conversion is left to the surrounding logic.

Top module: `stage_watchdog`

## Requirements
- R1: After reset the block is locked, every configuration field is zero, and `irq_level`, `irq_pulse`, `cpu_rst` and `sys_rst` are all low.
- R2: A write to address 0 with data equal to parameter `KEY` unlocks the block from the next clock. A write to address 0 with any other data locks it from the next clock. Address 0 can always be written.
- R3: While the block is locked, writes to address 1 (config), address 2 (prescale), address 3 (feed) and addresses 8 to 11 (timeouts) are ignored.
- R4: The prescale register at address 2 (bits PRE_W-1:0) gives the number of clocks per tick. A value of 0 behaves like 1.
- R5: Stage s (0 to 3) has a timeout register at address 8+s (bits CNT_W-1:0). The stage ends on the tick that brings its tick count to that timeout, where 0 behaves like 1. The sequence then moves to stage s+1, and after stage 3 to stage 0.
- R6: The action of stage s is config bits [5+2s:4+2s]: 0 = none, 1 = interrupt, 2 = CPU reset, 3 = system reset. A stage with code 0 ends without any change at the outputs.
- R7: A write to address 3 while unlocked clears the prescaler and the tick count, returns to stage 0 and clears `irq_level`. It takes priority over a stage ending in the same clock.
- R8: When level interrupts are enabled (config bit 1), an interrupt action sets `irq_level`. It stays set until a feed, or until a write to address 4 with data bit 0 set. That clear write is accepted even while the block is locked, and a new interrupt in the same clock wins over it.
- R9: When edge interrupts are enabled (config bit 2), an interrupt action drives `irq_pulse` high for exactly one clock. With a type's enable at 0, that output does not respond to interrupt actions.
- R10: A CPU-reset action drives `cpu_rst` high for (config bits [14:12]) + 1 clocks. A system-reset action drives `sys_rst` high for (config bits [17:15]) + 1 clocks. Each pulse starts on the clock edge at which the stage ends, and a new action reloads the length.
- R11: The watchdog runs while config bit 0 (enable) or config bit 3 (boot mode) is 1. While both are 0, the prescaler, the tick count and the stage are held at zero and no action occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Register write data |
| irq_level | output | 1 | Sticky interrupt level |
| irq_pulse | output | 1 | One-clock interrupt pulse |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
The bench builds the block with 16-bit timeouts and an 8-bit prescaler, and programs timeouts of only a few ticks at prescale values of 0, 1 and 3. This lets complete four-stage cycles, including the wrap from stage 3 to stage 0, repeat many times within a short run. The 3-bit reset-length fields are exercised at both ends, 0 and 7. At the fastest settings a stage can end on every clock, so back-to-back actions, pulse reloads and the interplay of interrupt-clear with a new interrupt all occur.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int NSTAGE = 4;
    localparam int STG_W  = $clog2(NSTAGE);
    localparam int LEN_W  = 3;
    localparam int CFG_W  = 4 + 2 * NSTAGE + 2 * LEN_W;

    // register addresses
    localparam int A_KEY  = 0;
    localparam int A_CFG  = 1;
    localparam int A_PRE  = 2;
    localparam int A_FEED = 3;
    localparam int A_CLR  = 4;
    localparam int A_TMO  = 8;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_IRQ  = 2'd1,
        ACT_CPU  = 2'd2,
        ACT_SYS  = 2'd3
    } wdt_act_e;

    typedef struct packed {
        logic [LEN_W-1:0]             sys_len;
        logic [LEN_W-1:0]             cpu_len;
        wdt_act_e [NSTAGE-1:0]        act;
        logic                         boot;
        logic                         edge_en;
        logic                         lvl_en;
        logic                         en;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int          CNT_W  = 32,
    parameter int          PRE_W  = 16,
    parameter int          ADDR_W = 4,
    parameter logic [31:0] KEY    = 32'hA5C3_0F96
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [31:0]                    wr_data,
    output logic                           unlocked,
    output wdt_cfg_t                       cfg,
    output logic [PRE_W-1:0]               prescale,
    output logic [NSTAGE-1:0][CNT_W-1:0]   timeout,
    output logic                           feed,
    output logic                           irq_clr
);
    typedef struct packed {
        logic                         unl;
        wdt_cfg_t                     cfg;
        logic [PRE_W-1:0]             pre;
        logic [NSTAGE-1:0][CNT_W-1:0] tmo;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(A_KEY)) begin
                d.unl = (wr_data == KEY);
            end
            if (q.unl) begin
                if (wr_addr == ADDR_W'(A_CFG)) begin
                    d.cfg = wdt_cfg_t'(wr_data[CFG_W-1:0]);
                end
                if (wr_addr == ADDR_W'(A_PRE)) begin
                    d.pre = wr_data[PRE_W-1:0];
                end
                for (int s = 0; s < NSTAGE; s++) begin
                    if (wr_addr == ADDR_W'(A_TMO + s)) begin
                        d.tmo[s] = wr_data[CNT_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign unlocked = q.unl;
    assign cfg      = q.cfg;
    assign prescale = q.pre;
    assign timeout  = q.tmo;
    assign feed     = wr_en && q.unl && (wr_addr == ADDR_W'(A_FEED));
    assign irq_clr  = wr_en && wr_data[0] && (wr_addr == ADDR_W'(A_CLR));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         active,
    input  logic [PRE_W-1:0]             prescale,
    input  logic [NSTAGE-1:0][CNT_W-1:0] timeout,
    input  wdt_act_e [NSTAGE-1:0]        act,
    input  logic                         lvl_en,
    input  logic                         edge_en,
    input  logic                         feed,
    input  logic                         irq_clr,
    output logic [STG_W-1:0]             stage,
    output logic                         expire,
    output logic                         irq_level,
    output logic                         irq_pulse,
    output logic                         fire_cpu,
    output logic                         fire_sys
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic [STG_W-1:0] stg;
        logic             irq;
        logic             pls;
    } core_t;

    core_t q, d;

    logic [PRE_W-1:0] pre_eff;
    logic [CNT_W-1:0] tmo_cur;
    logic             tick;
    logic             last;
    wdt_act_e         act_cur;
    logic             irq_hit;

    always_comb begin
        pre_eff = (prescale == '0) ? PRE_W'(1) : prescale;
        tmo_cur = timeout[q.stg];
        act_cur = act[q.stg];
        tick    = ({1'b0, q.pre} + (PRE_W+1)'(1)) >= {1'b0, pre_eff};
        last    = ({1'b0, q.cnt} + (CNT_W+1)'(1)) >= {1'b0, tmo_cur};
        expire  = active && !feed && tick && last;
        irq_hit = expire && (act_cur == ACT_IRQ);

        d     = q;
        d.pls = irq_hit && edge_en;
        if (feed || !active) begin
            d.pre = '0;
            d.cnt = '0;
            d.stg = '0;
        end else if (tick) begin
            d.pre = '0;
            if (last) begin
                d.cnt = '0;
                d.stg = (q.stg == STG_W'(NSTAGE - 1)) ? '0 : q.stg + STG_W'(1);
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end else begin
            d.pre = q.pre + PRE_W'(1);
        end

        if (irq_hit && lvl_en) begin
            d.irq = 1'b1;
        end else if (feed || irq_clr) begin
            d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stage     = q.stg;
    assign irq_level = q.irq;
    assign irq_pulse = q.pls;
    assign fire_cpu  = expire && (act_cur == ACT_CPU);
    assign fire_sys  = expire && (act_cur == ACT_SYS);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    output logic             pulse
);
    localparam int CW = LEN_W + 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (fire) begin
            cnt_d = {1'b0, len} + CW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
    import wdt_pkg::*;
#(
    parameter int          CNT_W  = 32,
    parameter int          PRE_W  = 16,
    parameter int          ADDR_W = 4,
    parameter logic [31:0] KEY    = 32'hA5C3_0F96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              irq_level,
    output logic              irq_pulse,
    output logic              cpu_rst,
    output logic              sys_rst
);
    localparam int NPULSE = 2;

    logic                         unlocked;
    wdt_cfg_t                     cfg;
    logic [PRE_W-1:0]             prescale;
    logic [NSTAGE-1:0][CNT_W-1:0] timeout;
    logic                         feed;
    logic                         irq_clr;
    logic                         active;
    logic [STG_W-1:0]             stage;
    logic                         expire;
    logic                         fire_cpu;
    logic                         fire_sys;
    logic [NPULSE-1:0]            fire_vec;
    logic [NPULSE-1:0][LEN_W-1:0] len_vec;
    logic [NPULSE-1:0]            pulse_vec;

    wdt_regs #(
        .CNT_W (CNT_W),
        .PRE_W (PRE_W),
        .ADDR_W(ADDR_W),
        .KEY   (KEY)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .unlocked(unlocked),
        .cfg     (cfg),
        .prescale(prescale),
        .timeout (timeout),
        .feed    (feed),
        .irq_clr (irq_clr)
    );

    assign active = cfg.en | cfg.boot;

    wdt_core #(
        .CNT_W(CNT_W),
        .PRE_W(PRE_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .prescale (prescale),
        .timeout  (timeout),
        .act      (cfg.act),
        .lvl_en   (cfg.lvl_en),
        .edge_en  (cfg.edge_en),
        .feed     (feed),
        .irq_clr  (irq_clr),
        .stage    (stage),
        .expire   (expire),
        .irq_level(irq_level),
        .irq_pulse(irq_pulse),
        .fire_cpu (fire_cpu),
        .fire_sys (fire_sys)
    );

    assign fire_vec = {fire_sys, fire_cpu};
    assign len_vec  = {cfg.sys_len, cfg.cpu_len};

    for (genvar p = 0; p < NPULSE; p++) begin : g_pulse
        wdt_pulse #(.LEN_W(LEN_W)) u_pulse (
            .clk  (clk),
            .rst_n(rst_n),
            .fire (fire_vec[p]),
            .len  (len_vec[p]),
            .pulse(pulse_vec[p])
        );
    end

    assign cpu_rst = pulse_vec[0];
    assign sys_rst = pulse_vec[1];
endmodule

// File: rtl/stage_watchdog_chk.sv
module stage_watchdog_chk
    import wdt_pkg::*;
#(
    parameter int          ADDR_W = 4,
    parameter logic [31:0] KEY    = 32'hA5C3_0F96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              unlocked,
    input logic [CFG_W-1:0]  cfg_bits,
    input logic              active,
    input logic              feed,
    input logic [STG_W-1:0]  stage,
    input logic              expire,
    input logic              fire_cpu,
    input logic              fire_sys,
    input logic              cpu_rst,
    input logic              sys_rst
);
    // R2
    key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_KEY) && wr_data == KEY) |=> unlocked);

    // R2
    key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_KEY) && wr_data != KEY) |=> !unlocked);

    // R3
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_CFG) && !unlocked) |=> $stable(cfg_bits));

    // R5
    stage_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && stage == STG_W'(NSTAGE - 1)) |=> (stage == '0));

    // R7
    feed_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed |=> (stage == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (stage == '0));

    // R10
    cpu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_cpu |=> cpu_rst);

    // R10
    sys_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_sys |=> sys_rst);
endmodule

bind stage_watchdog stage_watchdog_chk #(
    .ADDR_W(ADDR_W),
    .KEY   (KEY)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .unlocked(unlocked),
    .cfg_bits(cfg),
    .active  (active),
    .feed    (feed),
    .stage   (stage),
    .expire  (expire),
    .fire_cpu(fire_cpu),
    .fire_sys(fire_sys),
    .cpu_rst (cpu_rst),
    .sys_rst (sys_rst)
);

// File: tb/stage_watchdog_test.sv
`timescale 1ns/1ps
module stage_watchdog_test;
    localparam int          CNT_W  = 16;
    localparam int          PRE_W  = 8;
    localparam int          ADDR_W = 4;
    localparam logic [31:0] KEY    = 32'hA5C3_0F96;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              irq_level, irq_pulse, cpu_rst, sys_rst;

    always #2.5 clk = ~clk;

    stage_watchdog #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .KEY(KEY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_level(irq_level), .irq_pulse(irq_pulse),
        .cpu_rst(cpu_rst), .sys_rst(sys_rst)
    );

    // behavioural reference state
    int    m_unl, m_en, m_lvl, m_edg, m_boot, m_clen, m_slen, m_pre;
    int    m_act[4];
    int    m_tmo[4];
    int    m_pc, m_tc, m_st, m_irq, m_pls, m_ccnt, m_scnt;
    int    compared = 0;
    int    mismatched = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_unl = 0; m_en = 0; m_lvl = 0; m_edg = 0; m_boot = 0;
            m_clen = 0; m_slen = 0; m_pre = 0;
            for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_tmo[i] = 0; end
            m_pc = 0; m_tc = 0; m_st = 0; m_irq = 0; m_pls = 0; m_ccnt = 0; m_scnt = 0;
        end else begin
            int  pe, a, lim;
            bit  fd, clr, run, ex;
            fd  = wr_en && m_unl != 0 && wr_addr == 3;
            clr = wr_en && wr_addr == 4 && wr_data[0];
            run = (m_en != 0) || (m_boot != 0);
            pe  = (m_pre == 0) ? 1 : m_pre;
            ex  = 0;
            a   = 0;
            if (fd || !run) begin
                m_pc = 0; m_tc = 0; m_st = 0;
            end else if (m_pc + 1 >= pe) begin
                m_pc = 0;
                lim  = m_tmo[m_st];
                if (m_tc + 1 >= lim) begin
                    ex = 1; a = m_act[m_st]; m_tc = 0; m_st = (m_st + 1) % 4;
                end else begin
                    m_tc++;
                end
            end else begin
                m_pc++;
            end
            if (ex && a == 1 && m_lvl != 0) m_irq = 1;
            else if (fd || clr) m_irq = 0;
            m_pls = (ex && a == 1 && m_edg != 0) ? 1 : 0;
            if (ex && a == 2) m_ccnt = m_clen + 1; else if (m_ccnt > 0) m_ccnt--;
            if (ex && a == 3) m_scnt = m_slen + 1; else if (m_scnt > 0) m_scnt--;
            if (wr_en && m_unl != 0) begin
                if (wr_addr == 1) begin
                    m_en = wr_data[0]; m_lvl = wr_data[1]; m_edg = wr_data[2]; m_boot = wr_data[3];
                    for (int i = 0; i < 4; i++) m_act[i] = (wr_data >> (4 + 2 * i)) & 3;
                    m_clen = (wr_data >> 12) & 7;
                    m_slen = (wr_data >> 15) & 7;
                end
                if (wr_addr == 2) m_pre = wr_data & 32'hFF;
                for (int i = 0; i < 4; i++)
                    if (wr_addr == 8 + i) m_tmo[i] = wr_data & 32'hFFFF;
            end
            if (wr_en && wr_addr == 0) m_unl = (wr_data == KEY) ? 1 : 0;
        end
    end

    task automatic cmp(input string nm, input logic act, input int exp);
        compared++;
        if (act !== exp[0]) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0d", cur_req, nm, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        cmp("irq_level", irq_level, m_irq);
        cmp("irq_pulse", irq_pulse, m_pls);
        cmp("cpu_rst", cpu_rst, (m_ccnt > 0) ? 1 : 0);
        cmp("sys_rst", sys_rst, (m_scnt > 0) ? 1 : 0);
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mkcfg(input int en, input int lvl, input int edg, input int boot,
                                          input int a0, input int a1, input int a2, input int a3,
                                          input int clen, input int slen);
        return 32'(en | (lvl << 1) | (edg << 2) | (boot << 3) | (a0 << 4) | (a1 << 6) |
                   (a2 << 8) | (a3 << 10) | (clen << 12) | (slen << 15));
    endfunction

    task automatic set_tmo(input int t0, input int t1, input int t2, input int t3);
        wr(8, t0); wr(9, t1); wr(10, t2); wr(11, t3);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(6);

        // R3: locked writes have no effect
        cur_req = "R3";
        wr(2, 1);
        set_tmo(1, 1, 1, 1);
        wr(1, mkcfg(1, 1, 1, 0, 1, 2, 3, 1, 1, 1));
        wr(3, 1);
        idle(30);

        // R2: key opens, other value closes
        cur_req = "R2";
        wr(0, KEY);
        wr(0, 32'h5);
        wr(1, mkcfg(1, 1, 1, 0, 1, 2, 3, 1, 1, 1));
        idle(20);
        wr(0, KEY);

        // R4 R5 R6: prescaled four-stage cycling with an off stage
        cur_req = "R4 R5 R6";
        wr(2, 3);
        set_tmo(2, 3, 1, 4);
        wr(1, mkcfg(1, 1, 1, 0, 1, 0, 2, 3, 2, 5));
        idle(100);

        // R8: clear accepted while locked
        cur_req = "R8";
        wr(0, 0);
        wr(4, 1);
        idle(3);
        wr(4, 0);
        idle(10);
        wr(0, KEY);

        // R7: frequent feeding holds stage 0 and clears the level
        cur_req = "R7";
        for (int k = 0; k < 10; k++) begin
            wr(3, 0);
            idle(2);
        end
        idle(40);
        wr(3, 0);
        idle(5);

        // R9: interrupt type enables
        cur_req = "R9";
        wr(1, mkcfg(1, 0, 0, 0, 1, 1, 1, 1, 0, 0));
        idle(40);
        wr(1, mkcfg(1, 0, 1, 0, 1, 1, 1, 1, 0, 0));
        wr(2, 1);
        set_tmo(1, 1, 1, 1);
        idle(20);

        // R10: reset pulse lengths at both ends of the field
        cur_req = "R10";
        wr(2, 1);
        set_tmo(1, 1, 8, 8);
        wr(1, mkcfg(1, 1, 1, 0, 2, 3, 2, 3, 0, 7));
        idle(60);
        wr(1, mkcfg(1, 1, 1, 0, 2, 3, 2, 3, 7, 0));
        idle(60);

        // R11: boot mode runs, both off holds, zero prescale and timeout
        cur_req = "R11";
        wr(2, 0);
        set_tmo(0, 2, 0, 1);
        wr(1, mkcfg(0, 1, 1, 1, 1, 2, 3, 1, 1, 2));
        idle(30);
        wr(1, mkcfg(0, 1, 1, 0, 1, 2, 3, 1, 1, 2));
        idle(20);
        wr(1, mkcfg(1, 1, 1, 0, 3, 1, 2, 1, 3, 1));
        idle(30);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule